// File: doc/BRIEF.md
# Self-Programming Command Window Controller

This block is the command and status register that arms an operation on the program memory. Software writes a command into its low five bits. Only five command codes are legal, and each one opens a short arming window. A store strobe from the CPU that arrives inside the four-cycle window starts the armed operation. The operation is one of these:

- load a word into the page buffer;
- erase a page;
- write a page.

A separate three-cycle window lets a load strobe return a fuse or lock byte instead of reading program memory. Writing the clear-buffer code produces a one-cycle buffer-clear pulse.

The controller drives the strobes for the external flash engine and the page field of the address. It holds the CPU halted while a page erase or page write is running, and it waits for the engine's done input to end the operation. Fuse and lock values arrive as "programmed" flags and are returned inverted, so a programmed bit reads as 0. While an EEPROM write is in progress, command writes and fuse/lock reads are refused.

Top module: `selfprog_cmd_ctrl`

## Requirements
- R1: After reset the register reads 0x00, the CPU is not halted and no strobe is active. Bits 7:5 of the register always read zero.
- R2: A register write takes effect only when its low five bits are one of these codes: 5'b00001 (buffer load), 5'b00011 (erase), 5'b00101 (write), 5'b01001 (fuse/lock read) or 5'b10001 (clear buffer). Bits 7:5 of the written value are ignored. Any other low-five-bit value leaves the register unchanged.
- R3: After an accepted store-type command, a store strobe is honoured in each of the next four cycles. If none arrives, all bits clear at the end of the fourth cycle.
- R4: With code 00001 armed, a store strobe asserts `bufLoad` for that cycle, and the register then clears.
- R5: With code 00011 or 00101 armed, a store strobe asserts `pageErase` or `pageWrite` for that cycle. In that cycle `pageAddr` equals `zAddr[ADDR_W-1:PAGE_LSB]`. From the next cycle `cpuHalt` is high and the register keeps its code until the cycle after `opDone`, when both clear.
- R6: With code 01001 armed, a load strobe in any of the next three cycles asserts `loadDataValid`, and the register clears. If no load strobe arrives, the bits clear at the end of the third cycle.
- R7: The fuse/lock read returns the inverted low fuse flags at address 0x0000 and the inverted high fuse flags at 0x0003. At 0x0001 it returns 0xFC OR the inverted lock flags in bits 1:0. Any other address returns 0xFF.
- R8: While `eepromBusy` is high, register writes are ignored and a load strobe returns no fuse/lock data. The armed read window is left intact.
- R9: A load strobe that does not produce a fuse/lock read asserts `progReadReq` in the same cycle.
- R10: An accepted write restarts the window count from zero.
- R11: Code 10001 asserts `bufClear` for exactly the cycle after the write, and then the register clears.
- R12: Register writes and `opDone` pulses received while no operation is running, and writes received during an operation, do not change the register beyond the rules above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read value |
| storeStrobe | input | 1 | CPU executes a store-to-program-memory instruction |
| loadStrobe | input | 1 | CPU executes a load-from-program-memory instruction |
| zAddr | input | ADDR_W | Address pointer from the CPU |
| eepromBusy | input | 1 | EEPROM write in progress |
| opDone | input | 1 | Flash engine finished erase/write |
| fuseLowProg | input | 8 | Low fuse byte, 1 = programmed |
| fuseHighProg | input | 8 | High fuse byte, 1 = programmed |
| lockProg | input | LOCK_W | Lock bits, 1 = programmed |
| bufLoad | output | 1 | Load word into page buffer |
| bufClear | output | 1 | Clear page buffer |
| pageErase | output | 1 | Start page erase |
| pageWrite | output | 1 | Start page write |
| pageAddr | output | ADDR_W-PAGE_LSB | Page field of the address |
| cpuHalt | output | 1 | Halt the CPU during erase/write |
| loadData | output | 8 | Fuse/lock byte read |
| loadDataValid | output | 1 | `loadData` is valid this cycle |
| progReadReq | output | 1 | Pass the load through as a normal program read |

## Verification
The bench builds the block with ADDR_W=16, PAGE_LSB=5, STORE_WIN=4 and LOAD_WIN=3. These short windows let every window edge be hit one cycle inside and one cycle outside. The 11-bit page field shows that the low word bits are dropped from `pageAddr`. A behavioural model follows the register, the window age and the busy state, and it predicts every output in every cycle. The sequences cover illegal codes, restarted windows, erase/write with halt and done, all fuse addresses, EEPROM blocking and pass-through reads.

// File: rtl/spc_pkg.sv
package spc_pkg;

  typedef struct packed {
    logic clrBuf;
    logic rdFuse;
    logic pgWrite;
    logic pgErase;
    logic enable;
  } spc_bits_t;

  typedef struct packed {
    logic bufLd;
    logic bufClr;
    logic ersStart;
    logic wrStart;
    logic fuseRd;
  } spc_strobe_t;

  localparam logic [4:0] CODE_LOAD  = 5'b00001;
  localparam logic [4:0] CODE_ERASE = 5'b00011;
  localparam logic [4:0] CODE_WRITE = 5'b00101;
  localparam logic [4:0] CODE_FUSE  = 5'b01001;
  localparam logic [4:0] CODE_CLR   = 5'b10001;

  function automatic logic isLegal(input logic [4:0] code);
    return (code == CODE_LOAD) || (code == CODE_ERASE) || (code == CODE_WRITE) ||
           (code == CODE_FUSE) || (code == CODE_CLR);
  endfunction

endpackage

// File: rtl/spc_ctrl.sv
module spc_ctrl
  import spc_pkg::*;
#(
  parameter int STORE_WIN = 4,
  parameter int LOAD_WIN  = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [4:0]  regWrLow,
  input  logic        storeStrobe,
  input  logic        loadStrobe,
  input  logic        eepromBusy,
  input  logic        opDone,
  output spc_bits_t   bits,
  output logic        busy,
  output spc_strobe_t stb
);

  localparam int MAX_WIN = (STORE_WIN > LOAD_WIN) ? STORE_WIN : LOAD_WIN;
  localparam int CNT_W   = $clog2(MAX_WIN + 1);
  localparam logic [CNT_W-1:0] STORE_LAST = CNT_W'(STORE_WIN - 1);
  localparam logic [CNT_W-1:0] LOAD_LAST  = CNT_W'(LOAD_WIN - 1);

  logic [CNT_W-1:0] winCnt;
  logic modeLoad, modeErase, modeWrite, modeFuse, modeClr;
  logic wrAccept, winLast;

  always_comb begin
    modeLoad  = bits.enable && !bits.rdFuse && !bits.pgErase && !bits.pgWrite && !bits.clrBuf;
    modeErase = bits.enable && bits.pgErase;
    modeWrite = bits.enable && bits.pgWrite;
    modeFuse  = bits.enable && bits.rdFuse;
    modeClr   = bits.enable && bits.clrBuf;
    wrAccept  = regWrEn && isLegal(regWrLow) && !eepromBusy && !busy;
    winLast   = modeFuse ? (winCnt == LOAD_LAST) : (winCnt == STORE_LAST);

    stb.bufLd    = storeStrobe && modeLoad && !busy;
    stb.ersStart = storeStrobe && modeErase && !busy;
    stb.wrStart  = storeStrobe && modeWrite && !busy;
    stb.bufClr   = modeClr && !busy;
    stb.fuseRd   = loadStrobe && modeFuse && !eepromBusy && !busy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bits   <= '0;
      busy   <= 1'b0;
      winCnt <= '0;
    end else if (busy) begin
      if (opDone) begin
        bits <= '0;
        busy <= 1'b0;
      end
    end else if (stb.ersStart || stb.wrStart) begin
      busy <= 1'b1;
    end else if (wrAccept) begin
      bits   <= spc_bits_t'(regWrLow);
      winCnt <= '0;
    end else if (stb.bufLd || stb.fuseRd || stb.bufClr) begin
      bits <= '0;
    end else if (bits.enable) begin
      if (winLast) bits <= '0;
      else winCnt <= winCnt + 1'b1;
    end
  end

  // R5
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && !opDone |=> busy && bits.enable);

  // R5
  op_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ersStart || stb.wrStart) |=> busy);

  // R3
  win_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bits.enable && !busy) |-> (winCnt < CNT_W'(MAX_WIN)));

  // R2
  illegal_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !isLegal(regWrLow) && bits == '0 && !busy) |=> bits == '0);

  // R8
  ee_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eepromBusy && regWrEn && bits == '0 && !busy) |=> bits == '0);

  // R4
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb));

  // R11
  clr_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.bufClr |=> !stb.bufClr);

endmodule

// File: rtl/spc_datapath.sv
module spc_datapath
  import spc_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int PAGE_LSB = 5,
  parameter int LOCK_W   = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  spc_strobe_t            stb,
  input  spc_bits_t              bits,
  input  logic                   busy,
  input  logic                   loadStrobe,
  input  logic [ADDR_W-1:0]      zAddr,
  input  logic [7:0]             fuseLowProg,
  input  logic [7:0]             fuseHighProg,
  input  logic [LOCK_W-1:0]      lockProg,
  output logic [7:0]             regRdData,
  output logic                   bufLoad,
  output logic                   bufClear,
  output logic                   pageErase,
  output logic                   pageWrite,
  output logic [ADDR_W-PAGE_LSB-1:0] pageAddr,
  output logic                   cpuHalt,
  output logic [7:0]             loadData,
  output logic                   loadDataValid,
  output logic                   progReadReq
);

  localparam logic [ADDR_W-1:0] ADDR_FLOW  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_LOCK  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_FHIGH = ADDR_W'(3);

  logic [7:0] lowRd, highRd, lockRd, selByte;

  for (genvar g = 0; g < 8; g++) begin : g_inv
    assign lowRd[g]  = ~fuseLowProg[g];
    assign highRd[g] = ~fuseHighProg[g];
    if (g < LOCK_W) begin : g_lk
      assign lockRd[g] = ~lockProg[g];
    end else begin : g_pad
      assign lockRd[g] = 1'b1;
    end
  end

  always_comb begin
    unique case (zAddr)
      ADDR_FLOW:  selByte = lowRd;
      ADDR_LOCK:  selByte = lockRd;
      ADDR_FHIGH: selByte = highRd;
      default:    selByte = 8'hFF;
    endcase
    regRdData     = {3'b000, bits};
    bufLoad       = stb.bufLd;
    bufClear      = stb.bufClr;
    pageErase     = stb.ersStart;
    pageWrite     = stb.wrStart;
    pageAddr      = zAddr[ADDR_W-1:PAGE_LSB];
    cpuHalt       = busy;
    loadDataValid = stb.fuseRd;
    loadData      = stb.fuseRd ? selByte : 8'h00;
    progReadReq   = loadStrobe && !stb.fuseRd;
  end

  // R9
  pass_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |-> (loadDataValid != progReadReq));

  // R5
  halt_no_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuHalt |-> !(pageErase || pageWrite || bufLoad));

endmodule

// File: rtl/selfprog_cmd_ctrl.sv
module selfprog_cmd_ctrl
  import spc_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int PAGE_LSB  = 5,
  parameter int LOCK_W    = 2,
  parameter int STORE_WIN = 4,
  parameter int LOAD_WIN  = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       regWrEn,
  input  logic [7:0]                 regWrData,
  output logic [7:0]                 regRdData,
  input  logic                       storeStrobe,
  input  logic                       loadStrobe,
  input  logic [ADDR_W-1:0]          zAddr,
  input  logic                       eepromBusy,
  input  logic                       opDone,
  input  logic [7:0]                 fuseLowProg,
  input  logic [7:0]                 fuseHighProg,
  input  logic [LOCK_W-1:0]          lockProg,
  output logic                       bufLoad,
  output logic                       bufClear,
  output logic                       pageErase,
  output logic                       pageWrite,
  output logic [ADDR_W-PAGE_LSB-1:0] pageAddr,
  output logic                       cpuHalt,
  output logic [7:0]                 loadData,
  output logic                       loadDataValid,
  output logic                       progReadReq
);

  spc_bits_t   bits;
  spc_strobe_t stb;
  logic        busy;

  spc_ctrl #(.STORE_WIN(STORE_WIN), .LOAD_WIN(LOAD_WIN)) i_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrLow(regWrData[4:0]),
    .storeStrobe(storeStrobe), .loadStrobe(loadStrobe), .eepromBusy(eepromBusy),
    .opDone(opDone), .bits(bits), .busy(busy), .stb(stb)
  );

  spc_datapath #(.ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB), .LOCK_W(LOCK_W)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .bits(bits), .busy(busy),
    .loadStrobe(loadStrobe), .zAddr(zAddr), .fuseLowProg(fuseLowProg),
    .fuseHighProg(fuseHighProg), .lockProg(lockProg), .regRdData(regRdData),
    .bufLoad(bufLoad), .bufClear(bufClear), .pageErase(pageErase),
    .pageWrite(pageWrite), .pageAddr(pageAddr), .cpuHalt(cpuHalt),
    .loadData(loadData), .loadDataValid(loadDataValid), .progReadReq(progReadReq)
  );

endmodule

// File: tb/test_selfprog_cmd_ctrl.sv
`timescale 1ns/1ps
module test_selfprog_cmd_ctrl;

  localparam int ADDR_W = 16, PAGE_LSB = 5, LOCK_W = 2, STORE_WIN = 4, LOAD_WIN = 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic regWrEn = 0, storeStrobe = 0, loadStrobe = 0, eepromBusy = 0, opDone = 0;
  logic [7:0] regWrData = 0;
  logic [ADDR_W-1:0] zAddr = 0;
  logic [7:0] fuseLowProg = 8'hA5, fuseHighProg = 8'h0F;
  logic [LOCK_W-1:0] lockProg = 2'b01;
  logic [7:0] regRdData, loadData;
  logic bufLoad, bufClear, pageErase, pageWrite, cpuHalt, loadDataValid, progReadReq;
  logic [ADDR_W-PAGE_LSB-1:0] pageAddr;

  always #4 clk = ~clk;

  selfprog_cmd_ctrl #(.ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB), .LOCK_W(LOCK_W),
    .STORE_WIN(STORE_WIN), .LOAD_WIN(LOAD_WIN)) i_selfprog_cmd_ctrl (.*);

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // behavioural model state
  int mCode = 0;    // armed code, 0 when idle
  int mAge = 0;     // cycles since accepted write
  bit mBusy = 0;

  function automatic bit legalCode(int c);
    return c == 1 || c == 3 || c == 5 || c == 9 || c == 17;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit wr = 0, int wd = 0, bit st = 0, bit ld = 0,
                      int a = 0, bit ee = 0, bit dn = 0);
    bit eBl, eBc, eEr, eWr, eFr;
    int eData;
    @(negedge clk);
    regWrEn = wr; regWrData = 8'(wd); storeStrobe = st; loadStrobe = ld;
    zAddr = ADDR_W'(a); eepromBusy = ee; opDone = dn;
    #1;
    eBc = (mCode == 17) && !mBusy;
    eBl = st && mCode == 1 && !mBusy;
    eEr = st && mCode == 3 && !mBusy;
    eWr = st && mCode == 5 && !mBusy;
    eFr = ld && mCode == 9 && !ee && !mBusy;
    case (a)
      0: eData = ~32'hA5 & 32'hFF;
      1: eData = 32'hFE;
      3: eData = 32'hF0;
      default: eData = 32'hFF;
    endcase
    if (!eFr) eData = 0;
    chk(tag, "regRdData", regRdData, mCode);
    chk(tag, "bufLoad", bufLoad, eBl);
    chk(tag, "bufClear", bufClear, eBc);
    chk(tag, "pageErase", pageErase, eEr);
    chk(tag, "pageWrite", pageWrite, eWr);
    chk(tag, "cpuHalt", cpuHalt, mBusy);
    chk(tag, "loadDataValid", loadDataValid, eFr);
    chk(tag, "loadData", loadData, eData);
    chk(tag, "progReadReq", progReadReq, ld && !eFr);
    if (eEr || eWr) chk(tag, "pageAddr", pageAddr, (a >> PAGE_LSB) & ((1 << (ADDR_W-PAGE_LSB)) - 1));
    @(posedge clk);
    if (mBusy) begin
      if (dn) begin mBusy = 0; mCode = 0; end
    end else if (eEr || eWr) mBusy = 1;
    else if (wr && legalCode(wd & 31) && !ee) begin mCode = wd & 31; mAge = 0; end
    else if (eBl || eFr || eBc) mCode = 0;
    else if (mCode != 0) begin
      mAge++;
      if (mAge >= ((mCode == 9) ? LOAD_WIN : STORE_WIN)) mCode = 0;
    end
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    step("R1");
    // R2 illegal codes and upper-bit masking
    step("R2", 1, 8'h07); step("R2");
    step("R2", 1, 8'h1F); step("R2");
    step("R2", 1, 8'hE1);
    // R3 window expiry after four cycles
    idle("R3", 5);
    // R4 store on the fourth cycle
    step("R4", 1, 8'h01); idle("R3", 3); step("R4", 0, 0, 1); step("R4");
    // R3 store on the fifth cycle is too late
    step("R3", 1, 8'h01); idle("R3", 4); step("R3", 0, 0, 1);
    // R10 restart
    step("R10", 1, 8'h01); idle("R10", 3); step("R10", 1, 8'h01); idle("R10", 3);
    step("R10", 0, 0, 1);
    // R5 erase, with R12 write during busy and opDone while idle
    step("R12", 0, 0, 0, 0, 0, 0, 1);
    step("R5", 1, 8'h03); step("R5", 0, 0, 1, 0, 16'h1234);
    step("R12", 1, 8'h01); idle("R5", 3); step("R5", 0, 0, 0, 0, 0, 0, 1); idle("R5", 2);
    // R5 write
    step("R5", 1, 8'h05); step("R5"); step("R5", 0, 0, 1, 0, 16'hFFE0);
    idle("R5", 2); step("R5", 0, 0, 0, 0, 0, 0, 1); step("R5");
    // R6/R7 fuse reads
    step("R6", 1, 8'h09); step("R7", 0, 0, 0, 1, 0);
    step("R6", 1, 8'h09); idle("R6", 2); step("R7", 0, 0, 0, 1, 1);
    step("R6", 1, 8'h09); step("R7", 0, 0, 0, 1, 3);
    step("R6", 1, 8'h09); step("R7", 0, 0, 0, 1, 2);
    step("R6", 1, 8'h09); idle("R6", 3); step("R9", 0, 0, 0, 1, 0);
    // R9 plain load
    step("R9", 0, 0, 0, 1, 16'h0400);
    // R8 EEPROM busy
    step("R8", 1, 8'h01, 0, 0, 0, 1); step("R8");
    step("R8", 1, 8'h09); step("R8", 0, 0, 0, 1, 0, 1); step("R8", 0, 0, 0, 1, 3);
    // R11 clear buffer
    step("R11", 1, 8'h11); step("R11"); step("R11");
    idle("R1", 2);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule